// File: doc/BRIEF.md
# Multi-Mode PWM Timer Core

This block is a 16-bit timer/counter core. A 4-bit mode input selects one of fifteen counting behaviours: free-running up-count, clear-on-compare, fast (single-slope) PWM, phase-correct (dual-slope) PWM, and phase-and-frequency-correct PWM. The turnaround value (TOP) is either a fixed width (8, 9, 10 or 16 bits) or comes from the active compare value or from a capture value that is supplied at an input.

The compare value is held in two stages. A write always lands in a holding register. The active value, which the counter is compared against, takes the held value either at once, at the top turnaround, or at the bottom/wrap point, depending on the mode. The counter advances only on cycles where the tick input (the prescaler's enable) is high. Two one-cycle strobes report an overflow event and a compare match. The prescaler and the waveform pin logic sit outside this block.

Top module: `pwm_timer16`

## Requirements
- R1: While rst_ni is low, count_o, cmp_active_o, ovf_o and match_o are all zero.
- R2: Mode 0 counts up by one on each tick and wraps from 0xFFFF to 0. ovf_o pulses for one cycle after the tick taken at 0xFFFF. With tick_i low, count_o holds and neither strobe fires.
- R3: Modes 4 (TOP = active compare) and 12 (TOP = cap_val_i) count up and go to 0 on the tick taken at TOP. ovf_o pulses only after a tick taken at 0xFFFF.
- R4: Fast PWM modes 5, 6 and 7 (TOP 0x00FF, 0x01FF, 0x03FF), 14 (TOP = cap_val_i) and 15 (TOP = active compare) count up and go to 0 on the tick at TOP. ovf_o pulses after that tick.
- R5: Phase-correct modes 1, 2 and 3 (fixed TOPs as in R4), 10 (cap_val_i) and 11 (active compare) count up until count ≥ TOP, then count down to 0, then count up again. ovf_o pulses after the tick taken at 0 while counting down.
- R6: Modes 8 (TOP = cap_val_i) and 9 (TOP = active compare) count as in R5 and pulse ovf_o after the tick taken at the bottom.
- R7: In modes 0, 4 and 12, a write (cmp_wr_i high) sets cmp_active_o to cmp_wdata_i on the next edge, whether or not a tick is present.
- R8: In modes 1, 2, 3, 10 and 11, the active compare loads the held value on the tick at the top turnaround. In modes 5, 6, 7, 8, 9, 14 and 15, it loads on the tick at the wrap point or the bottom. In all these modes, it does not change otherwise.
- R9: If a write coincides with a load tick, the active value takes the previously held value. The new write takes effect at the next load point.
- R10: match_o pulses for one cycle after any tick where count_o equals cmp_active_o. This applies while counting up or down, in every mode except 13.
- R11: In reserved mode 13, count_o and cmp_active_o hold, and neither ovf_o nor match_o fires. Writes only update the held value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Count enable from the prescaler |
| mode_i | input | 4 | Waveform mode select, 0 to 15 |
| cmp_wr_i | input | 1 | Compare value write strobe |
| cmp_wdata_i | input | 16 | Compare value write data |
| cap_val_i | input | 16 | Capture register value, used as TOP in modes 8, 10, 12 and 14 |
| count_o | output | 16 | Counter value |
| ovf_o | output | 1 | One-cycle overflow event strobe |
| match_o | output | 1 | One-cycle compare-match strobe |
| cmp_active_o | output | 16 | Compare value currently in effect |

## Verification
A compare write and a buffered load can occur on the same tick. In mode 15, TOP is the active compare value, so that collision also moves the wrap point. The bench steers the counter to TOP and writes on exactly the wrapping tick. It then expects the previously held value to become active, and the newly written value only one period later. Random segments also hit this collision, and a match together with an overflow at TOP, in the buffered modes. A cycle-level bench model judges every cycle.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

    localparam int MODE_W = 4;

    typedef enum logic [1:0] {
        SEQ_UP_WRAP,
        SEQ_UP_DOWN,
        SEQ_HOLD
    } seq_e;

    typedef enum logic [2:0] {
        TOP_FULL,
        TOP_FIX8,
        TOP_FIX9,
        TOP_FIX10,
        TOP_CAP,
        TOP_CMP
    } top_e;

    typedef enum logic [1:0] {
        UPD_NOW,
        UPD_AT_TOP,
        UPD_AT_BOT,
        UPD_NONE
    } upd_e;

    typedef enum logic [1:0] {
        FLG_MAX,
        FLG_TOP,
        FLG_BOT,
        FLG_NONE
    } flg_e;

    typedef struct packed {
        seq_e seq;
        top_e top;
        upd_e upd;
        flg_e flg;
    } mode_cfg_t;

endpackage

// File: rtl/pwm_mode_decode.sv
module pwm_mode_decode
    import pwm_timer_pkg::*;
(
    input  logic [MODE_W-1:0] mode_i,
    output mode_cfg_t         cfg_o
);

    always_comb begin
        cfg_o = '{seq: SEQ_HOLD, top: TOP_FULL, upd: UPD_NONE, flg: FLG_NONE};
        case (mode_i)
            4'd0:  cfg_o = '{seq: SEQ_UP_WRAP, top: TOP_FULL,  upd: UPD_NOW,    flg: FLG_MAX};
            4'd1:  cfg_o = '{seq: SEQ_UP_DOWN, top: TOP_FIX8,  upd: UPD_AT_TOP, flg: FLG_BOT};
            4'd2:  cfg_o = '{seq: SEQ_UP_DOWN, top: TOP_FIX9,  upd: UPD_AT_TOP, flg: FLG_BOT};
            4'd3:  cfg_o = '{seq: SEQ_UP_DOWN, top: TOP_FIX10, upd: UPD_AT_TOP, flg: FLG_BOT};
            4'd4:  cfg_o = '{seq: SEQ_UP_WRAP, top: TOP_CMP,   upd: UPD_NOW,    flg: FLG_MAX};
            4'd5:  cfg_o = '{seq: SEQ_UP_WRAP, top: TOP_FIX8,  upd: UPD_AT_BOT, flg: FLG_TOP};
            4'd6:  cfg_o = '{seq: SEQ_UP_WRAP, top: TOP_FIX9,  upd: UPD_AT_BOT, flg: FLG_TOP};
            4'd7:  cfg_o = '{seq: SEQ_UP_WRAP, top: TOP_FIX10, upd: UPD_AT_BOT, flg: FLG_TOP};
            4'd8:  cfg_o = '{seq: SEQ_UP_DOWN, top: TOP_CAP,   upd: UPD_AT_BOT, flg: FLG_BOT};
            4'd9:  cfg_o = '{seq: SEQ_UP_DOWN, top: TOP_CMP,   upd: UPD_AT_BOT, flg: FLG_BOT};
            4'd10: cfg_o = '{seq: SEQ_UP_DOWN, top: TOP_CAP,   upd: UPD_AT_TOP, flg: FLG_BOT};
            4'd11: cfg_o = '{seq: SEQ_UP_DOWN, top: TOP_CMP,   upd: UPD_AT_TOP, flg: FLG_BOT};
            4'd12: cfg_o = '{seq: SEQ_UP_WRAP, top: TOP_CAP,   upd: UPD_NOW,    flg: FLG_MAX};
            4'd14: cfg_o = '{seq: SEQ_UP_WRAP, top: TOP_CAP,   upd: UPD_AT_BOT, flg: FLG_TOP};
            4'd15: cfg_o = '{seq: SEQ_UP_WRAP, top: TOP_CMP,   upd: UPD_AT_BOT, flg: FLG_TOP};
            default: cfg_o = '{seq: SEQ_HOLD, top: TOP_FULL, upd: UPD_NONE, flg: FLG_NONE};
        endcase
    end

endmodule

// File: rtl/pwm_top_select.sv
module pwm_top_select
    import pwm_timer_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  top_e             sel_i,
    input  logic [WIDTH-1:0] cap_i,
    input  logic [WIDTH-1:0] cmp_i,
    output logic [WIDTH-1:0] top_o
);

    localparam logic [WIDTH-1:0] TopF8   = WIDTH'((1 << 8) - 1);
    localparam logic [WIDTH-1:0] TopF9   = WIDTH'((1 << 9) - 1);
    localparam logic [WIDTH-1:0] TopF10  = WIDTH'((1 << 10) - 1);
    localparam logic [WIDTH-1:0] TopFull = '1;

    always_comb begin
        case (sel_i)
            TOP_FIX8:  top_o = TopF8;
            TOP_FIX9:  top_o = TopF9;
            TOP_FIX10: top_o = TopF10;
            TOP_CAP:   top_o = cap_i;
            TOP_CMP:   top_o = cmp_i;
            default:   top_o = TopFull;
        endcase
    end

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
    import pwm_timer_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  seq_e             seq_i,
    input  flg_e             flg_i,
    input  logic [WIDTH-1:0] top_i,
    output logic [WIDTH-1:0] count_o,
    output logic             ev_top_o,
    output logic             ev_bot_o,
    output logic             ovf_o
);

    localparam logic [WIDTH-1:0] CntMax = '1;

    typedef struct packed {
        logic [WIDTH-1:0] cnt;
        logic             down;
        logic             ovf;
    } cnt_state_t;

    cnt_state_t state_d, state_q;
    logic       ev_max;

    always_comb begin
        state_d     = state_q;
        state_d.ovf = 1'b0;
        ev_top_o    = 1'b0;
        ev_bot_o    = 1'b0;
        ev_max      = 1'b0;
        if (tick_i) begin
            case (seq_i)
                SEQ_UP_WRAP: begin
                    state_d.down = 1'b0;
                    ev_max       = (state_q.cnt == CntMax);
                    if (state_q.cnt == top_i) begin
                        ev_top_o    = 1'b1;
                        ev_bot_o    = 1'b1;
                        state_d.cnt = '0;
                    end else begin
                        state_d.cnt = state_q.cnt + 1'b1;
                    end
                end
                SEQ_UP_DOWN: begin
                    if (!state_q.down) begin
                        if (state_q.cnt >= top_i) begin
                            ev_top_o     = 1'b1;
                            state_d.down = 1'b1;
                            state_d.cnt  = (state_q.cnt == '0) ? '0 : state_q.cnt - 1'b1;
                        end else begin
                            state_d.cnt = state_q.cnt + 1'b1;
                        end
                    end else begin
                        if (state_q.cnt == '0) begin
                            ev_bot_o     = 1'b1;
                            state_d.down = 1'b0;
                            state_d.cnt  = (top_i == '0) ? '0 : WIDTH'(1);
                        end else begin
                            state_d.cnt = state_q.cnt - 1'b1;
                        end
                    end
                end
                default: state_d = state_q;
            endcase
            case (flg_i)
                FLG_MAX: state_d.ovf = ev_max;
                FLG_TOP: state_d.ovf = ev_top_o;
                FLG_BOT: state_d.ovf = ev_bot_o;
                default: state_d.ovf = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign count_o = state_q.cnt;
    assign ovf_o   = state_q.ovf;

endmodule

// File: rtl/pwm_compare.sv
module pwm_compare
    import pwm_timer_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  seq_e             seq_i,
    input  upd_e             upd_i,
    input  logic             ev_top_i,
    input  logic             ev_bot_i,
    input  logic [WIDTH-1:0] count_i,
    input  logic             wr_i,
    input  logic [WIDTH-1:0] wdata_i,
    output logic [WIDTH-1:0] active_o,
    output logic             match_o
);

    typedef struct packed {
        logic [WIDTH-1:0] held;
        logic [WIDTH-1:0] act;
        logic             match;
    } cmp_state_t;

    cmp_state_t state_d, state_q;

    always_comb begin
        state_d       = state_q;
        state_d.match = tick_i && (seq_i != SEQ_HOLD) && (count_i == state_q.act);
        if (wr_i) begin
            state_d.held = wdata_i;
        end
        case (upd_i)
            UPD_NOW: begin
                if (wr_i) state_d.act = wdata_i;
            end
            UPD_AT_TOP: begin
                if (ev_top_i) state_d.act = state_q.held;
            end
            UPD_AT_BOT: begin
                if (ev_bot_i) state_d.act = state_q.held;
            end
            default: state_d.act = state_q.act;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign active_o = state_q.act;
    assign match_o  = state_q.match;

endmodule

// File: rtl/pwm_timer16.sv
module pwm_timer16
    import pwm_timer_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              cmp_wr_i,
    input  logic [WIDTH-1:0]  cmp_wdata_i,
    input  logic [WIDTH-1:0]  cap_val_i,
    output logic [WIDTH-1:0]  count_o,
    output logic              ovf_o,
    output logic              match_o,
    output logic [WIDTH-1:0]  cmp_active_o
);

    mode_cfg_t        cfg;
    logic [WIDTH-1:0] top_val;
    logic [WIDTH-1:0] count_w;
    logic [WIDTH-1:0] active_w;
    logic             ev_top;
    logic             ev_bot;

    pwm_mode_decode i_decode (
        .mode_i (mode_i),
        .cfg_o  (cfg)
    );

    pwm_top_select #(.WIDTH(WIDTH)) i_top_sel (
        .sel_i (cfg.top),
        .cap_i (cap_val_i),
        .cmp_i (active_w),
        .top_o (top_val)
    );

    pwm_counter #(.WIDTH(WIDTH)) i_counter (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .tick_i   (tick_i),
        .seq_i    (cfg.seq),
        .flg_i    (cfg.flg),
        .top_i    (top_val),
        .count_o  (count_w),
        .ev_top_o (ev_top),
        .ev_bot_o (ev_bot),
        .ovf_o    (ovf_o)
    );

    pwm_compare #(.WIDTH(WIDTH)) i_compare (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .tick_i   (tick_i),
        .seq_i    (cfg.seq),
        .upd_i    (cfg.upd),
        .ev_top_i (ev_top),
        .ev_bot_i (ev_bot),
        .count_i  (count_w),
        .wr_i     (cmp_wr_i),
        .wdata_i  (cmp_wdata_i),
        .active_o (active_w),
        .match_o  (match_o)
    );

    assign count_o      = count_w;
    assign cmp_active_o = active_w;

endmodule

// File: rtl/pwm_timer16_chk.sv
module pwm_timer16_chk #(
    parameter int WIDTH = 16
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             tick_i,
    input logic [3:0]       mode_i,
    input logic             cmp_wr_i,
    input logic [WIDTH-1:0] cmp_wdata_i,
    input logic [WIDTH-1:0] count_o,
    input logic             ovf_o,
    input logic             match_o,
    input logic [WIDTH-1:0] cmp_active_o
);

    logic imm_mode;
    assign imm_mode = (mode_i == 4'd0) || (mode_i == 4'd4) || (mode_i == 4'd12);

    p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick_i |=> ($stable(count_o) && !ovf_o && !match_o));

    p_wrap_max_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && mode_i == 4'd0 && count_o == '1) |=> (ovf_o && count_o == '0));

    p_imm_update_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmp_wr_i && imm_mode) |=> (cmp_active_o == $past(cmp_wdata_i)));

    p_buf_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick_i && !imm_mode) |=> $stable(cmp_active_o));

    p_match_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && mode_i != 4'd13 && count_o == cmp_active_o) |=> match_o);

    p_reserved_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == 4'd13) |=> ($stable(count_o) && $stable(cmp_active_o) && !ovf_o && !match_o));

endmodule

bind pwm_timer16 pwm_timer16_chk #(.WIDTH(WIDTH)) i_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick_i),
    .mode_i       (mode_i),
    .cmp_wr_i     (cmp_wr_i),
    .cmp_wdata_i  (cmp_wdata_i),
    .count_o      (count_o),
    .ovf_o        (ovf_o),
    .match_o      (match_o),
    .cmp_active_o (cmp_active_o)
);

// File: tb/test_pwm_timer16.sv
`timescale 1ns/1ps
module test_pwm_timer16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [3:0]  mode = 4'd0;
    logic        wr = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] cap = '0;
    logic [15:0] count;
    logic        ovf;
    logic        match;
    logic [15:0] active;

    int checks = 0;
    int errors = 0;

    logic [15:0] m_cnt = '0, m_held = '0, m_act = '0;
    bit          m_down = 0, m_ovf = 0, m_match = 0;
    logic [3:0]  cur_mode = 4'd0;

    always #2.5 clk = ~clk;

    pwm_timer16 i_pwm_timer16 (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .mode_i(mode),
        .cmp_wr_i(wr), .cmp_wdata_i(wdata), .cap_val_i(cap),
        .count_o(count), .ovf_o(ovf), .match_o(match), .cmp_active_o(active)
    );

    function automatic logic [15:0] ref_top(logic [3:0] md, logic [15:0] cv, logic [15:0] act);
        case (md)
            4'd1, 4'd5: return 16'h00FF;
            4'd2, 4'd6: return 16'h01FF;
            4'd3, 4'd7: return 16'h03FF;
            4'd4, 4'd9, 4'd11, 4'd15: return act;
            4'd8, 4'd10, 4'd12, 4'd14: return cv;
            default: return 16'hFFFF;
        endcase
    endfunction

    function automatic string cnt_tag(logic [3:0] md);
        case (md)
            4'd0: return "R2";
            4'd4, 4'd12: return "R3";
            4'd5, 4'd6, 4'd7, 4'd14, 4'd15: return "R4";
            4'd8, 4'd9: return "R6";
            4'd13: return "R11";
            default: return "R5";
        endcase
    endfunction

    task automatic chk(string tag, string what, logic [15:0] act_v, logic [15:0] exp_v);
        checks++;
        if (act_v !== exp_v) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act_v, exp_v);
        end
    endtask

    task automatic ref_step(bit tk, logic [3:0] md, bit w, logic [15:0] wd, logic [15:0] cv);
        logic [15:0] top = ref_top(md, cv, m_act);
        logic [15:0] n_cnt = m_cnt, n_act = m_act;
        bit n_down = m_down, at_top = 0, at_bot = 0, at_max = 0, n_ovf;
        bit wrapm = md inside {4'd0, 4'd4, 4'd5, 4'd6, 4'd7, 4'd12, 4'd14, 4'd15};
        bit updn  = md inside {4'd1, 4'd2, 4'd3, 4'd8, 4'd9, 4'd10, 4'd11};
        bit n_match = tk && (md != 4'd13) && (m_cnt == m_act);
        if (tk && wrapm) begin
            n_down = 0;
            at_max = (m_cnt == 16'hFFFF);
            if (m_cnt == top) begin at_top = 1; at_bot = 1; n_cnt = '0; end
            else n_cnt = m_cnt + 16'd1;
        end else if (tk && updn) begin
            if (!m_down) begin
                if (m_cnt >= top) begin
                    at_top = 1; n_down = 1;
                    n_cnt = (m_cnt == 0) ? 16'd0 : m_cnt - 16'd1;
                end else n_cnt = m_cnt + 16'd1;
            end else begin
                if (m_cnt == 0) begin
                    at_bot = 1; n_down = 0;
                    n_cnt = (top == 0) ? 16'd0 : 16'd1;
                end else n_cnt = m_cnt - 16'd1;
            end
        end
        if (md inside {4'd0, 4'd4, 4'd12}) n_ovf = at_max;
        else if (md inside {4'd5, 4'd6, 4'd7, 4'd14, 4'd15}) n_ovf = at_top;
        else if (updn) n_ovf = at_bot;
        else n_ovf = 0;
        if (md inside {4'd0, 4'd4, 4'd12}) begin
            if (w) n_act = wd;
        end else if (md inside {4'd1, 4'd2, 4'd3, 4'd10, 4'd11}) begin
            if (at_top) n_act = m_held;
        end else if (md != 4'd13) begin
            if (at_bot) n_act = m_held;
        end
        if (w) m_held = wd;
        m_cnt = n_cnt; m_down = n_down; m_act = n_act; m_ovf = n_ovf; m_match = n_match;
    endtask

    task automatic cycle(bit tk, logic [3:0] md, bit w, logic [15:0] wd, logic [15:0] cv);
        tick = tk; mode = md; wr = w; wdata = wd; cap = cv;
        ref_step(tk, md, w, wd, cv);
        cur_mode = md;
        @(negedge clk);
        chk(cnt_tag(cur_mode), "count", count, m_cnt);
        chk(cnt_tag(cur_mode), "overflow", {15'd0, ovf}, {15'd0, m_ovf});
        chk("R10", "match", {15'd0, match}, {15'd0, m_match});
        chk((cur_mode inside {4'd0, 4'd4, 4'd12}) ? "R7" : "R8", "active compare", active, m_act);
    endtask

    initial begin
        #(5.0 * 190000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] hold_cnt, hold_act;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R1", "reset count", count, 16'd0);
        chk("R1", "reset overflow", {15'd0, ovf}, 16'd0);
        chk("R1", "reset match", {15'd0, match}, 16'd0);
        chk("R1", "reset active", active, 16'd0);
        rst_n = 1'b1;

        // R2: idle ticks, immediate write, then a full 16-bit wrap
        for (int i = 0; i < 5; i++) cycle(0, 4'd0, (i == 2), 16'd3, 16'd0);
        for (int i = 0; i < 65538; i++) cycle(1, 4'd0, 0, 16'd0, 16'd0);
        chk("R2", "count after full wrap", count, 16'd2);

        // R9: write on the wrapping tick in mode 15
        cycle(1, 4'd4, 1, 16'd10, 16'd0);
        for (int g = 0; g < 40 && m_cnt != m_act; g++) cycle(1, 4'd15, 0, 16'd0, 16'd0);
        cycle(1, 4'd15, 1, 16'd20, 16'd0);
        chk("R9", "active after colliding write", active, 16'd10);
        cycle(1, 4'd15, 0, 16'd0, 16'd0);
        for (int g = 0; g < 40 && m_cnt != m_act; g++) cycle(1, 4'd15, 0, 16'd0, 16'd0);
        cycle(1, 4'd15, 0, 16'd0, 16'd0);
        chk("R9", "active at next wrap", active, 16'd20);

        // R11: reserved mode holds
        hold_cnt = count; hold_act = active;
        for (int i = 0; i < 6; i++) cycle(1, 4'd13, (i == 1), 16'd5, 16'd7);
        chk("R11", "count held", count, hold_cnt);
        chk("R11", "active held", active, hold_act);
        chk("R11", "no overflow", {15'd0, ovf}, 16'd0);
        chk("R11", "no match", {15'd0, match}, 16'd0);

        // R4 / R5: fixed-TOP modes
        for (int i = 0; i < 300; i++)  cycle(1, 4'd5, (i == 7), 16'd40, 16'd0);
        for (int i = 0; i < 600; i++)  cycle(1, 4'd1, (i == 9), 16'd90, 16'd0);
        for (int i = 0; i < 520; i++)  cycle(1, 4'd6, 0, 16'd0, 16'd0);
        for (int i = 0; i < 1030; i++) cycle(1, 4'd2, 0, 16'd0, 16'd0);
        for (int i = 0; i < 1100; i++) cycle(1, 4'd7, 0, 16'd0, 16'd0);
        for (int i = 0; i < 2100; i++) cycle(1, 4'd3, 0, 16'd0, 16'd0);

        // Random segments over the programmable-TOP modes
        for (int s = 0; s < 300; s++) begin
            logic [3:0]  md;
            logic [15:0] cv;
            int          len;
            md = 4'(8 + $urandom_range(0, 7));
            if ($urandom_range(0, 4) == 0) md = 4'd4;
            cv = 16'($urandom_range(0, 63));
            if ((md inside {4'd4, 4'd12, 4'd14, 4'd15}) && (ref_top(md, cv, m_act) < m_cnt)) md = 4'd10;
            len = $urandom_range(5, 60);
            for (int i = 0; i < len; i++) begin
                bit tk = ($urandom_range(0, 9) < 7);
                bit w  = (md != 4'd4) && ($urandom_range(0, 3) == 0);
                cycle(tk, md, w, 16'($urandom_range(0, 63)), cv);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule